// File: doc/BRIEF.md
# Serial Control-Word Loader for a Dual Synthesizer

This block sits between a three-wire serial port and the divider logic of a two-channel frequency synthesizer. A host shifts a configuration word in on a data line, clocked by a serial clock, and then raises a load strobe. The two bits shifted in last name one of four destination latches. The other bits carry that latch's payload. A reference latch holds a reference divide ratio and a mode field. A main latch holds a main divide ratio, a prescaler modulus select and a run bit. Channel 1 is the high-frequency channel and channel 2 is the low-frequency channel.

The three serial inputs are sampled by the system clock. Edges on these inputs are detected with one register stage followed by an edge comparator. After each load, the shift register is cleared. This lets a host send a short word, which then reads as zero-padded at the top. Downstream logic sees only the latched contents.

Top module: `sdl_loader`

## Requirements
- R1: On each rising edge of the serial clock, the data bit shifts into a 22-bit register at the bottom, so the first bit sent ends up most significant. Bits pushed past the top are lost, so a longer word keeps only its last 22 bits.
- R2: Word bits [1:0] select the destination latch: 00 is the channel-2 reference latch, 01 the channel-1 reference latch, 10 the channel-2 main latch, and 11 the channel-1 main latch.
- R3: In a reference word, bits [16:2] are the 15-bit reference divide ratio and bits [21:17] are the 5-bit mode field.
- R4: In a channel-1 main word, bits [19:2] are the 18-bit main divide ratio, bit 20 is the prescaler modulus select and bit 21 is the run bit.
- R5: In a channel-2 main word, bits [16:2] are the 15-bit main divide ratio, bit 17 is the prescaler select and bit 18 is the run bit. Bits [21:19] are ignored.
- R6: A rising edge of the load strobe writes only the addressed latch. The other three latches keep their contents.
- R7: Shifting bits while the load strobe stays low changes no latched output.
- R8: Each load clears the shift register, so a word shorter than 22 bits reads as zero in the bits not sent.
- R9: After reset, every latched field is zero. Each channel's power-down output is the inverse of its run bit, so both channels read as powered down after reset.
- R10: Holding the load strobe high performs one load only. Bits shifted while the strobe stays high do not reach any latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, sampled by clk |
| ser_data | input | 1 | Serial data, first bit sent is most significant |
| ser_le | input | 1 | Load strobe, acts on its rising edge |
| ch1_ref_div | output | REF_W (15) | Channel-1 reference divide ratio |
| ch1_mode | output | MODE_W (5) | Channel-1 mode field |
| ch1_main_div | output | MAIN1_W (18) | Channel-1 main divide ratio |
| ch1_presc_hi | output | 1 | Channel-1 prescaler modulus select |
| ch1_pwdn | output | 1 | Channel-1 powered down |
| ch2_ref_div | output | REF_W (15) | Channel-2 reference divide ratio |
| ch2_mode | output | MODE_W (5) | Channel-2 mode field |
| ch2_main_div | output | MAIN2_W (15) | Channel-2 main divide ratio |
| ch2_presc_hi | output | 1 | Channel-2 prescaler modulus select |
| ch2_pwdn | output | 1 | Channel-2 powered down |

## Verification
The bench builds the block with its default widths: 15-bit reference ratios, a 5-bit mode field and main ratios of 18 and 15 bits. These widths give a 22-bit word. They let the bench reach the bit-21 run bit of channel 1 and the three ignored top bits of a channel-2 main word, and check that both are decoded at the intended positions. Two word lengths test the clearing and overflow behaviour: a 12-bit word shows the zero padding, and a 25-bit word shows the oldest bits falling off the top.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

    localparam int CTRL_W = 2;

    typedef enum logic [CTRL_W-1:0] {
        TGT_REF2  = 2'b00,
        TGT_REF1  = 2'b01,
        TGT_MAIN2 = 2'b10,
        TGT_MAIN1 = 2'b11
    } target_e;

    localparam int NUM_TGT = 1 << CTRL_W;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Payload bits needed: largest of the reference and main word layouts.
    function automatic int payload_bits(input int ref_w, input int mode_w,
                                        input int m1_w, input int m2_w);
        return max2(ref_w + mode_w, max2(m1_w + 2, m2_w + 2));
    endfunction

endpackage

// File: rtl/sdl_shifter.sv
module sdl_shifter #(
    parameter int SR_W = 22
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ser_clk,
    input  logic            ser_data,
    input  logic            ser_le,
    output logic [SR_W-1:0] sr,
    output logic            commit
);
    logic clk_q, clk_qq, dat_q, le_q, le_qq;
    logic shift_evt;

    assign shift_evt = clk_q & ~clk_qq;
    assign commit    = le_q & ~le_qq;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q  <= 1'b0;
            clk_qq <= 1'b0;
            dat_q  <= 1'b0;
            le_q   <= 1'b0;
            le_qq  <= 1'b0;
            sr     <= '0;
        end else begin
            clk_q  <= ser_clk;
            clk_qq <= clk_q;
            dat_q  <= ser_data;
            le_q   <= ser_le;
            le_qq  <= le_q;
            if (commit)
                sr <= '0;
            else if (shift_evt)
                sr <= {sr[SR_W-2:0], dat_q};
        end
    end

    AST_SR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        commit |=> (sr == '0)); // R8

    AST_SR_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!shift_evt && !commit) |=> $stable(sr)); // R1

endmodule

// File: rtl/sdl_decode.sv
module sdl_decode
    import sdl_pkg::*;
(
    input  logic               commit,
    input  logic [CTRL_W-1:0]  ctrl,
    output logic [NUM_TGT-1:0] sel
);
    target_e tgt;

    assign tgt = target_e'(ctrl);

    always_comb begin
        sel = '0;
        if (commit) begin
            case (tgt)
                TGT_REF2:  sel[TGT_REF2]  = 1'b1;
                TGT_REF1:  sel[TGT_REF1]  = 1'b1;
                TGT_MAIN2: sel[TGT_MAIN2] = 1'b1;
                TGT_MAIN1: sel[TGT_MAIN1] = 1'b1;
                default:   sel = '0;
            endcase
        end
    end

    always_comb begin
        assert ($onehot0(sel)); // R2 AST_ONE_TARGET
    end

endmodule

// File: rtl/sdl_chan_latch.sv
module sdl_chan_latch #(
    parameter int PAY_W  = 20,
    parameter int REF_W  = 15,
    parameter int MODE_W = 5,
    parameter int MAIN_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_ref,
    input  logic              ld_main,
    input  logic [PAY_W-1:0]  payload,
    output logic [REF_W-1:0]  ref_div,
    output logic [MODE_W-1:0] mode,
    output logic [MAIN_W-1:0] main_div,
    output logic              presc_hi,
    output logic              run
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_div <= '0;
            mode    <= '0;
        end else if (ld_ref) begin
            ref_div <= payload[REF_W-1:0];
            mode    <= payload[REF_W+MODE_W-1:REF_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            main_div <= '0;
            presc_hi <= 1'b0;
            run      <= 1'b0;
        end else if (ld_main) begin
            main_div <= payload[MAIN_W-1:0];
            presc_hi <= payload[MAIN_W];
            run      <= payload[MAIN_W+1];
        end
    end

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        !(ld_ref || ld_main) |=> $stable({ref_div, mode, main_div, presc_hi, run})); // R7

    AST_REF_SPARES_MAIN: assert property (@(posedge clk) disable iff (rst)
        (ld_ref && !ld_main) |=> $stable({main_div, presc_hi, run})); // R6

endmodule

// File: rtl/sdl_loader.sv
module sdl_loader
    import sdl_pkg::*;
#(
    parameter int REF_W   = 15,
    parameter int MODE_W  = 5,
    parameter int MAIN1_W = 18,
    parameter int MAIN2_W = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               ser_le,
    output logic [REF_W-1:0]   ch1_ref_div,
    output logic [MODE_W-1:0]  ch1_mode,
    output logic [MAIN1_W-1:0] ch1_main_div,
    output logic               ch1_presc_hi,
    output logic               ch1_pwdn,
    output logic [REF_W-1:0]   ch2_ref_div,
    output logic [MODE_W-1:0]  ch2_mode,
    output logic [MAIN2_W-1:0] ch2_main_div,
    output logic               ch2_presc_hi,
    output logic               ch2_pwdn
);
    localparam int PAY_W    = payload_bits(REF_W, MODE_W, MAIN1_W, MAIN2_W);
    localparam int SR_W     = PAY_W + CTRL_W;
    localparam int MAIN_MAX = max2(MAIN1_W, MAIN2_W);

    logic [SR_W-1:0]    sr;
    logic               commit;
    logic [NUM_TGT-1:0] sel;

    logic [1:0][REF_W-1:0]    ref_arr;
    logic [1:0][MODE_W-1:0]   mode_arr;
    logic [1:0][MAIN_MAX-1:0] main_arr;
    logic [1:0]               presc_arr;
    logic [1:0]               run_arr;

    sdl_shifter #(.SR_W(SR_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_le   (ser_le),
        .sr       (sr),
        .commit   (commit)
    );

    sdl_decode u_dec (
        .commit (commit),
        .ctrl   (sr[CTRL_W-1:0]),
        .sel    (sel)
    );

    // Index 0 is channel 1, index 1 is channel 2.
    for (genvar i = 0; i < 2; i++) begin : g_ch
        localparam int      MW       = (i == 0) ? MAIN1_W : MAIN2_W;
        localparam target_e REF_CODE = (i == 0) ? TGT_REF1  : TGT_REF2;
        localparam target_e MAIN_CODE = (i == 0) ? TGT_MAIN1 : TGT_MAIN2;

        logic [MW-1:0] main_q;

        sdl_chan_latch #(
            .PAY_W  (PAY_W),
            .REF_W  (REF_W),
            .MODE_W (MODE_W),
            .MAIN_W (MW)
        ) u_lat (
            .clk      (clk),
            .rst      (rst),
            .ld_ref   (sel[REF_CODE]),
            .ld_main  (sel[MAIN_CODE]),
            .payload  (sr[SR_W-1:CTRL_W]),
            .ref_div  (ref_arr[i]),
            .mode     (mode_arr[i]),
            .main_div (main_q),
            .presc_hi (presc_arr[i]),
            .run      (run_arr[i])
        );

        assign main_arr[i] = MAIN_MAX'(main_q);
    end

    assign ch1_ref_div  = ref_arr[0];
    assign ch1_mode     = mode_arr[0];
    assign ch1_main_div = main_arr[0][MAIN1_W-1:0];
    assign ch1_presc_hi = presc_arr[0];
    assign ch1_pwdn     = ~run_arr[0];
    assign ch2_ref_div  = ref_arr[1];
    assign ch2_mode     = mode_arr[1];
    assign ch2_main_div = main_arr[1][MAIN2_W-1:0];
    assign ch2_presc_hi = presc_arr[1];
    assign ch2_pwdn     = ~run_arr[1];

    AST_CH1_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
        (sel[TGT_REF1] || sel[TGT_MAIN1]) |-> !(sel[TGT_REF2] || sel[TGT_MAIN2])); // R6

endmodule

// File: tb/tb_sdl_loader.sv
module tb_sdl_loader;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_le = 1'b0;

    logic [14:0] ch1_ref_div, ch2_ref_div, ch2_main_div;
    logic [4:0]  ch1_mode, ch2_mode;
    logic [17:0] ch1_main_div;
    logic        ch1_presc_hi, ch1_pwdn, ch2_presc_hi, ch2_pwdn;

    always #10 clk = ~clk; // 50 MHz

    sdl_loader dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ch1_ref_div(ch1_ref_div), .ch1_mode(ch1_mode), .ch1_main_div(ch1_main_div),
        .ch1_presc_hi(ch1_presc_hi), .ch1_pwdn(ch1_pwdn),
        .ch2_ref_div(ch2_ref_div), .ch2_mode(ch2_mode), .ch2_main_div(ch2_main_div),
        .ch2_presc_hi(ch2_presc_hi), .ch2_pwdn(ch2_pwdn)
    );

    typedef struct {
        string       tag;
        logic [14:0] r1, r2, n2;
        logic [4:0]  m1, m2;
        logic [17:0] n1;
        logic        p1, p2, run1, run2;
    } exp_t;

    exp_t model;
    exp_t sb_q[$];
    event chk_ev;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic cmp(input string tag, input string fld, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, fld, act, exp);
        end
    endtask

    // Monitor: pops the oldest expectation and compares every output.
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                cmp(e.tag, "ch1_ref_div",  ch1_ref_div,  e.r1);
                cmp(e.tag, "ch1_mode",     ch1_mode,     e.m1);
                cmp(e.tag, "ch1_main_div", ch1_main_div, e.n1);
                cmp(e.tag, "ch1_presc_hi", ch1_presc_hi, e.p1);
                cmp(e.tag, "ch1_pwdn",     ch1_pwdn,     !e.run1);
                cmp(e.tag, "ch2_ref_div",  ch2_ref_div,  e.r2);
                cmp(e.tag, "ch2_mode",     ch2_mode,     e.m2);
                cmp(e.tag, "ch2_main_div", ch2_main_div, e.n2);
                cmp(e.tag, "ch2_presc_hi", ch2_presc_hi, e.p2);
                cmp(e.tag, "ch2_pwdn",     ch2_pwdn,     !e.run2);
            end
        end
    end

    // Requirement model of a load (R2..R5).
    task automatic apply(input logic [21:0] w);
        case (w[1:0])
            2'b00: begin model.r2 = w[16:2]; model.m2 = w[21:17]; end
            2'b01: begin model.r1 = w[16:2]; model.m1 = w[21:17]; end
            2'b10: begin model.n2 = w[16:2]; model.p2 = w[17]; model.run2 = w[18]; end
            default: begin model.n1 = w[19:2]; model.p1 = w[20]; model.run1 = w[21]; end
        endcase
    endtask

    task automatic expect_now(input string tag);
        exp_t e;
        repeat (4) @(negedge clk);
        e = model;
        e.tag = tag;
        sb_q.push_back(e);
        -> chk_ev;
        @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_data = v[i];
            ser_clk  = 1'b0;
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (2) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic strobe();
        @(negedge clk);
        ser_le = 1'b1;
        repeat (3) @(negedge clk);
        ser_le = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send(input logic [21:0] w, input string tag);
        shift_bits({10'd0, w}, 22);
        strobe();
        apply(w);
        expect_now(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model = '{tag: "", r1: 0, r2: 0, n2: 0, m1: 0, m2: 0, n1: 0,
                  p1: 0, p2: 0, run1: 0, run2: 0};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_now("R9 reset state");

        // R2 R3: reference words for each channel
        send({5'h15, 15'h1234, 2'b01}, "R3 R2 ch1 reference");
        send({5'h0A, 15'h7FFF, 2'b00}, "R3 R6 ch2 reference");
        // R4: channel-1 main, run and prescaler set
        send({1'b1, 1'b1, 18'h2ABCD, 2'b11}, "R4 ch1 main");
        // R5: channel-2 main with ignored top bits set
        send({3'b111, 1'b1, 1'b0, 15'h4321, 2'b10}, "R5 ch2 main ignored bits");

        // R8: 12-bit word, upper bits padded with zero
        shift_bits({20'd0, 10'h3A5, 2'b11}, 12);
        strobe();
        apply({10'd0, 10'h3A5, 2'b11});
        expect_now("R8 short word padded");

        // R7: shift a full word with no strobe
        shift_bits({10'd0, 5'h1F, 15'h0F0F, 2'b01}, 22);
        expect_now("R7 shift without load");

        // R1: 25-bit word, first three bits fall off
        shift_bits({7'd0, 3'b101, 5'h1F, 15'h0001, 2'b00}, 25);
        strobe();
        apply({5'h1F, 15'h0001, 2'b00});
        expect_now("R1 overlong word");

        // R10: strobe held high while a second word shifts in
        shift_bits({10'd0, 5'h03, 15'h0555, 2'b01}, 22);
        @(negedge clk);
        ser_le = 1'b1;
        apply({5'h03, 15'h0555, 2'b01});
        expect_now("R10 first load");
        shift_bits({10'd0, 5'h1C, 15'h2AAA, 2'b11}, 22);
        expect_now("R10 held strobe no reload");
        @(negedge clk);
        ser_le = 1'b0;
        repeat (2) @(negedge clk);

        // R9: clearing the run bit powers channel 2 down again
        send({3'b000, 1'b0, 1'b1, 15'h0ABC, 2'b10}, "R9 ch2 run cleared");
        // R6: ch1 main rewrite leaves references untouched
        send({1'b0, 1'b0, 18'h3FFFF, 2'b11}, "R6 ch1 main all ones");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule